// File: doc/BRIEF.md
# Set-Associative Translation Buffer with Register Probe Port

The block is a small translation buffer that turns the upper 20 bits of a linear address, the page number, into the upper 20 bits of a physical address. It has four ways of eight sets each. Every entry holds a linear page number, a valid flag, three attribute flags (dirty, user, writable) and a physical page number. The set is chosen by the low three bits of the linear page number.

Software reaches the array through two 32-bit registers. The probe-command register takes a linear page number, a valid flag, three attribute pairs and an operation bit. The probe-data register holds a physical page number, a hit flag and a way number. A write to the command register acts at once. With the operation bit clear, it stores an entry in the way named by the data register. With the operation bit set, it searches every way of the indexed set. The result is registered and can be read from both registers one cycle later. A flush input drops every valid flag in one cycle.

Both registers are plain write-strobed control registers, so the block exerts no back-pressure. Every strobe is accepted in the cycle it is raised, and `lk_done` pulses in the cycle the result of a search becomes visible.

Top module: `tlb_probe`

## Requirements
- R1: After reset, `cmd_q`, `dat_q` and `lk_done` are zero, every entry is invalid, and a search with valid flag 1 misses.
- R2: A command write with operation bit 0 (bit 0) loads `cmd_q` with the written word. When the data register's hit flag (bit 4) is 1, the same write stores page number bits 31:12, valid bit 11 and the attributes into set bits 14:12 of the way named by data bits 3:2. It replaces any earlier entry in that slot and leaves `dat_q` unchanged.
- R3: A command write with operation bit 0 while the data register's hit flag is 0 stores nothing.
- R4: A command write with operation bit 1 raises `lk_done` for exactly the next cycle. If exactly one way matches, `dat_q` then shows hit flag 1, that way in bits 3:2 and the entry's physical page in bits 31:12. `cmd_q` shows the entry's attributes as true/complement pairs.
- R5: On a miss, the hit flag reads 0, the way and physical page fields keep their previous values, and `cmd_q` holds the written word.
- R6: During a search, the valid flag (bit 11) is compared like an address bit, so an entry stored with valid 0 is matched only by a search with valid 0.
- R7: Attribute pairs sit at bits 10:9 (dirty), 8:7 (user) and 6:5 (writable), each written {X, X-complement}. In a search, 01 requires a stored 0 and 10 requires a stored 1. 00 and 11 never match.
- R8: On an entry write, pair 10 stores 1, and pairs 01, 00 and 11 store 0.
- R9: A flush pulse clears every valid flag, so a search with valid 1 in the next cycle misses.
- R10: A data-register write loads `dat_q` with the written word in the next cycle. Without a data write or a search, `dat_q` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Clear all valid flags |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command word |
| dat_we | input | 1 | Data register write strobe |
| dat_wdata | input | 32 | Data word |
| cmd_q | output | 32 | Command register contents |
| dat_q | output | 32 | Data register contents |
| lk_done | output | 1 | Search result visible this cycle |

## Verification
The assertions assume that software never stores two valid entries with the same page number and valid flag in one set, since such duplicates give undefined results. They also assume that a data-register write is not issued in the same cycle as an entry write. The stimulus gives every stored entry a distinct page number or set, searches only with defined pairs unless it is checking the never-match rule, and spaces each strobe onto its own cycle. Flush is raised only in cycles without a command write, which is what the flush-then-miss property depends on.

// File: rtl/tlb_probe_pkg.sv
package tlb_probe_pkg;
  localparam int REG_W    = 32;
  localparam int PAGE_SH  = 12;
  localparam int PN_W     = REG_W - PAGE_SH;
  localparam int OP_BIT   = 0;
  localparam int VLD_BIT  = 11;
  localparam int DP_HI    = 10;
  localparam int UP_HI    = 8;
  localparam int WP_HI    = 6;
  localparam int HIT_BIT  = 4;
  localparam int WAY_LSB  = 2;

  typedef struct packed {
    logic d;
    logic u;
    logic w;
  } attr_t;

  function automatic logic pair_store(input logic [1:0] p);
    return p == 2'b10;
  endfunction

  function automatic logic pair_match(input logic [1:0] p, input logic stored);
    return (p == 2'b10 && stored) || (p == 2'b01 && !stored);
  endfunction
endpackage

// File: rtl/tlb_way_bank.sv
module tlb_way_bank
  import tlb_probe_pkg::*;
#(
  parameter int SETS = 8,
  parameter int PNW  = PN_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     wr_en,
  input  logic [$clog2(SETS)-1:0]  idx,
  input  logic [PNW-1:0]           key_lpn,
  input  logic                     key_v,
  input  logic [1:0]               key_dp,
  input  logic [1:0]               key_up,
  input  logic [1:0]               key_wp,
  input  logic [PNW-1:0]           wr_ppn,
  output logic                     match,
  output logic [PNW-1:0]           rd_ppn,
  output attr_t                    rd_attr
);
  localparam int IDX_W = $clog2(SETS);

  logic [SETS-1:0] vld;
  logic [PNW-1:0]  lpn_mem [SETS];
  logic [PNW-1:0]  ppn_mem [SETS];
  attr_t           attr_mem [SETS];
  attr_t           wr_attr;

  always_comb begin
    wr_attr.d = pair_store(key_dp);
    wr_attr.u = pair_store(key_up);
    wr_attr.w = pair_store(key_wp);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
    end else begin
      if (flush) vld <= '0;
      if (wr_en) vld[idx] <= key_v;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      lpn_mem[idx]  <= key_lpn;
      ppn_mem[idx]  <= wr_ppn;
      attr_mem[idx] <= wr_attr;
    end
  end

  always_comb begin
    rd_ppn  = ppn_mem[idx];
    rd_attr = attr_mem[idx];
    match   = (vld[idx] == key_v)
            && (lpn_mem[idx] == key_lpn)
            && pair_match(key_dp, rd_attr.d)
            && pair_match(key_up, rd_attr.u)
            && pair_match(key_wp, rd_attr.w);
  end

  logic [IDX_W-1:0] unused_idx_w;
  assign unused_idx_w = '0;
endmodule

// File: rtl/tlb_hit_resolve.sv
module tlb_hit_resolve
  import tlb_probe_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int PNW  = PN_W
) (
  input  logic [WAYS-1:0]          hit_vec,
  input  logic [PNW-1:0]           ppn_in  [WAYS],
  input  attr_t                    attr_in [WAYS],
  output logic                     unique_hit,
  output logic [$clog2(WAYS)-1:0]  hit_way,
  output logic [PNW-1:0]           hit_ppn,
  output attr_t                    hit_attr
);
  localparam int WAY_W = $clog2(WAYS);
  localparam int CNT_W = $clog2(WAYS + 1);

  logic [CNT_W-1:0] cnt;

  always_comb begin
    cnt      = '0;
    hit_way  = '0;
    hit_ppn  = '0;
    hit_attr = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (hit_vec[i]) begin
        cnt      = cnt + CNT_W'(1);
        hit_way  = WAY_W'(i);
        hit_ppn  = ppn_in[i];
        hit_attr = attr_in[i];
      end
    end
    unique_hit = (cnt == CNT_W'(1));
  end
endmodule

// File: rtl/tlb_probe.sv
module tlb_probe
  import tlb_probe_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              cmd_we,
  input  logic [REG_W-1:0]  cmd_wdata,
  input  logic              dat_we,
  input  logic [REG_W-1:0]  dat_wdata,
  output logic [REG_W-1:0]  cmd_q,
  output logic [REG_W-1:0]  dat_q,
  output logic              lk_done
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);

  logic [REG_W-1:0] creg, dreg, creg_nxt, dreg_nxt;
  logic             op_lookup, op_store;
  logic [IDX_W-1:0] set_idx;
  logic [PN_W-1:0]  key_lpn;
  logic [WAY_W-1:0] tgt_way;

  logic [WAYS-1:0]  hit_vec;
  logic [PN_W-1:0]  way_ppn  [WAYS];
  attr_t            way_attr [WAYS];

  logic             uhit;
  logic [WAY_W-1:0] sel_way;
  logic [PN_W-1:0]  sel_ppn;
  attr_t            sel_attr;

  assign op_lookup = cmd_we &  cmd_wdata[OP_BIT];
  assign op_store  = cmd_we & ~cmd_wdata[OP_BIT] & dreg[HIT_BIT];
  assign set_idx   = cmd_wdata[PAGE_SH +: IDX_W];
  assign key_lpn   = cmd_wdata[REG_W-1:PAGE_SH];
  assign tgt_way   = dreg[WAY_LSB +: WAY_W];

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    logic way_we;
    assign way_we = op_store && (tgt_way == WAY_W'(g));
    tlb_way_bank #(.SETS(SETS), .PNW(PN_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .wr_en   (way_we),
      .idx     (set_idx),
      .key_lpn (key_lpn),
      .key_v   (cmd_wdata[VLD_BIT]),
      .key_dp  (cmd_wdata[DP_HI -: 2]),
      .key_up  (cmd_wdata[UP_HI -: 2]),
      .key_wp  (cmd_wdata[WP_HI -: 2]),
      .wr_ppn  (dreg[REG_W-1:PAGE_SH]),
      .match   (hit_vec[g]),
      .rd_ppn  (way_ppn[g]),
      .rd_attr (way_attr[g])
    );
  end

  tlb_hit_resolve #(.WAYS(WAYS), .PNW(PN_W)) u_resolve (
    .hit_vec    (hit_vec),
    .ppn_in     (way_ppn),
    .attr_in    (way_attr),
    .unique_hit (uhit),
    .hit_way    (sel_way),
    .hit_ppn    (sel_ppn),
    .hit_attr   (sel_attr)
  );

  always_comb begin
    creg_nxt = creg;
    if (cmd_we) begin
      creg_nxt = cmd_wdata;
      if (op_lookup && uhit) begin
        creg_nxt[DP_HI -: 2] = {sel_attr.d, ~sel_attr.d};
        creg_nxt[UP_HI -: 2] = {sel_attr.u, ~sel_attr.u};
        creg_nxt[WP_HI -: 2] = {sel_attr.w, ~sel_attr.w};
      end
    end
  end

  always_comb begin
    dreg_nxt = dat_we ? dat_wdata : dreg;
    if (op_lookup) begin
      dreg_nxt[HIT_BIT] = uhit;
      if (uhit) begin
        dreg_nxt[WAY_LSB +: WAY_W]   = sel_way;
        dreg_nxt[REG_W-1:PAGE_SH]    = sel_ppn;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      creg    <= '0;
      dreg    <= '0;
      lk_done <= 1'b0;
    end else begin
      creg    <= creg_nxt;
      dreg    <= dreg_nxt;
      lk_done <= op_lookup;
    end
  end

  assign cmd_q = creg;
  assign dat_q = dreg;
endmodule

// File: rtl/tlb_probe_chk.sv
module tlb_probe_chk
  import tlb_probe_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             cmd_we,
  input logic [REG_W-1:0] cmd_wdata,
  input logic             dat_we,
  input logic [REG_W-1:0] dat_wdata,
  input logic [REG_W-1:0] cmd_q,
  input logic [REG_W-1:0] dat_q,
  input logic             lk_done
);
  assert_done_after_search_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_wdata[OP_BIT]) |=> lk_done);

  assert_no_stray_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_we && cmd_wdata[OP_BIT]) |=> !lk_done);

  assert_hit_pairs_complement_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_done && dat_q[HIT_BIT]) |->
      ((cmd_q[DP_HI] ^ cmd_q[DP_HI-1]) && (cmd_q[UP_HI] ^ cmd_q[UP_HI-1])
       && (cmd_q[WP_HI] ^ cmd_q[WP_HI-1])));

  assert_store_loads_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !cmd_wdata[OP_BIT]) |=> (cmd_q == $past(cmd_wdata)));

  assert_miss_keeps_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_wdata[OP_BIT] && !dat_we) |=>
      (dat_q[HIT_BIT] || (dat_q[REG_W-1:PAGE_SH] == $past(dat_q[REG_W-1:PAGE_SH]))));

  assert_flush_then_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !cmd_we) ##1 (cmd_we && cmd_wdata[OP_BIT] && cmd_wdata[VLD_BIT])
      |=> !dat_q[HIT_BIT]);

  assert_data_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && !(cmd_we && cmd_wdata[OP_BIT])) |=> (dat_q == $past(dat_wdata)));

  assert_data_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!dat_we && !(cmd_we && cmd_wdata[OP_BIT])) |=> $stable(dat_q));
endmodule

bind tlb_probe tlb_probe_chk u_chk (.*);

// File: tb/tlb_probe_tb.sv
module tlb_probe_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic        dat_we = 1'b0;
  logic [31:0] dat_wdata = '0;
  logic [31:0] cmd_q, dat_q;
  logic        lk_done;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_dat = '0;

  typedef struct {
    logic [31:0] cmd;
    logic [31:0] dat;
    string       req;
  } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_probe u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .dat_we(dat_we), .dat_wdata(dat_wdata),
    .cmd_q(cmd_q), .dat_q(dat_q), .lk_done(lk_done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // pairs given as {X, X#}; op 1 = search
  function automatic logic [31:0] mk_cmd(input logic [19:0] lpn, input logic v,
      input logic [1:0] dp, input logic [1:0] up, input logic [1:0] wp, input logic op);
    return {lpn, v, dp, up, wp, 4'b0000, op};
  endfunction

  function automatic logic [31:0] mk_dat(input logic [19:0] ppn, input logic ht,
      input logic [1:0] rep);
    return {ppn, 7'd0, ht, rep, 2'b00};
  endfunction

  always @(negedge clk) begin
    if (rst_n && lk_done) begin
      if (sb.size() == 0) begin
        checks++; fails++;
        $display("FAIL R4 unexpected lk_done actual=1 expected=0");
      end else begin
        item_t it;
        it = sb.pop_front();
        check({it.req, " dat_q"}, dat_q, it.dat);
        check({it.req, " cmd_q"}, cmd_q, it.cmd);
      end
    end
  end

  task automatic put_dat(input logic [31:0] w);
    @(negedge clk);
    dat_we = 1'b1; dat_wdata = w;
    @(negedge clk);
    dat_we = 1'b0;
    exp_dat = w;
    check("R10 data write", dat_q, w);
  endtask

  task automatic store(input logic [31:0] c);
    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = c;
    @(negedge clk);
    cmd_we = 1'b0;
    check("R2 cmd_q after store", cmd_q, c);
    check("R2 dat_q unchanged by store", dat_q, exp_dat);
  endtask

  task automatic search(input logic [31:0] c, input logic hit, input logic [1:0] rep,
      input logic [19:0] ppn, input string req);
    item_t it;
    if (hit) exp_dat = {ppn, exp_dat[11:5], 1'b1, rep, exp_dat[1:0]};
    else     exp_dat[4] = 1'b0;
    it.cmd = c; it.dat = exp_dat; it.req = req;
    sb.push_back(it);
    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = c;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 cmd_q reset", cmd_q, 32'h0);
    check("R1 dat_q reset", dat_q, 32'h0);
    check("R1 lk_done reset", {31'd0, lk_done}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: empty array misses
    search(mk_cmd(20'h12345, 1, 2'b10, 2'b01, 2'b10, 1), 0, 0, 0, "R1 empty miss");

    // R2/R4: store then find
    put_dat(mk_dat(20'hABCDE, 1, 2'd2));
    store(mk_cmd(20'h12345, 1, 2'b10, 2'b01, 2'b10, 0));
    put_dat(mk_dat(20'h00000, 0, 2'd0));
    search(mk_cmd(20'h12345, 1, 2'b10, 2'b01, 2'b10, 1), 1, 2'd2, 20'hABCDE, "R4 hit way2");

    // R7: wrong or undefined pair misses; R5 keeps page and way
    search(mk_cmd(20'h12345, 1, 2'b01, 2'b01, 2'b10, 1), 0, 0, 0, "R7 pair mismatch R5");
    search(mk_cmd(20'h12345, 1, 2'b11, 2'b01, 2'b10, 1), 0, 0, 0, "R7 pair 11 never matches");
    search(mk_cmd(20'h12345, 1, 2'b10, 2'b00, 2'b10, 1), 0, 0, 0, "R7 pair 00 never matches");

    // R6: valid flag compared like an address bit
    put_dat(mk_dat(20'h11111, 1, 2'd1));
    store(mk_cmd(20'h00777, 0, 2'b01, 2'b01, 2'b01, 0));
    search(mk_cmd(20'h00777, 0, 2'b01, 2'b01, 2'b01, 1), 1, 2'd1, 20'h11111, "R6 v0 hit");
    search(mk_cmd(20'h00777, 1, 2'b01, 2'b01, 2'b01, 1), 0, 0, 0, "R6 v1 miss");

    // R8: undefined pairs store 0
    put_dat(mk_dat(20'h55555, 1, 2'd3));
    store(mk_cmd(20'h22222, 1, 2'b11, 2'b00, 2'b10, 0));
    search(mk_cmd(20'h22222, 1, 2'b01, 2'b01, 2'b10, 1), 1, 2'd3, 20'h55555, "R8 stored zeros");
    search(mk_cmd(20'h22222, 1, 2'b10, 2'b01, 2'b10, 1), 0, 0, 0, "R8 stored d not one");

    // R3: store ignored when hit flag is 0
    put_dat(mk_dat(20'h33333, 0, 2'd0));
    store(mk_cmd(20'h44444, 1, 2'b01, 2'b01, 2'b01, 0));
    search(mk_cmd(20'h44444, 1, 2'b01, 2'b01, 2'b01, 1), 0, 0, 0, "R3 ignored store");

    // R2: two ways share set 0; overwrite in same slot
    put_dat(mk_dat(20'h0AAAA, 1, 2'd0));
    store(mk_cmd(20'h00010, 1, 2'b01, 2'b01, 2'b01, 0));
    put_dat(mk_dat(20'h0BBBB, 1, 2'd1));
    store(mk_cmd(20'h00008, 1, 2'b01, 2'b01, 2'b01, 0));
    search(mk_cmd(20'h00010, 1, 2'b01, 2'b01, 2'b01, 1), 1, 2'd0, 20'h0AAAA, "R2 set0 way0");
    search(mk_cmd(20'h00008, 1, 2'b01, 2'b01, 2'b01, 1), 1, 2'd1, 20'h0BBBB, "R2 set0 way1");
    put_dat(mk_dat(20'h0CCCC, 1, 2'd0));
    store(mk_cmd(20'h00018, 1, 2'b01, 2'b01, 2'b01, 0));
    search(mk_cmd(20'h00010, 1, 2'b01, 2'b01, 2'b01, 1), 0, 0, 0, "R2 replaced entry misses");
    search(mk_cmd(20'h00018, 1, 2'b01, 2'b01, 2'b01, 1), 1, 2'd0, 20'h0CCCC, "R2 new entry hits");

    // R9: flush clears all valid flags
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    search(mk_cmd(20'h12345, 1, 2'b10, 2'b01, 2'b10, 1), 0, 0, 0, "R9 flushed way2");
    search(mk_cmd(20'h00018, 1, 2'b01, 2'b01, 2'b01, 1), 0, 0, 0, "R9 flushed way0");

    // R10: data register holds with no writes
    repeat (3) @(negedge clk);
    check("R10 dat_q hold", dat_q, exp_dat);
    check("R4 scoreboard drained", 32'(sb.size()), 32'd0);

    summary();
    $finish;
  end
endmodule